// File: doc/BRIEF.md
# Supply Reset Sequencer

This block generates the chip-wide system reset from two digital supply-monitor flags. One flag reports that the supply is above the power-on level. The other reports that it is above the brown-out level. While either flag is low, the block holds the system reset asserted.

Once both flags are good, it times a series of settling intervals on a free-running reference clock before it releases reset:
- a short bias-settling interval, used only after a loss of the power-on flag;
- a regulator-settling interval;
- a power-up delay chosen by a 3-bit configuration code.

A fall of either flag at any point sends the block back to its hold phase, and the intervals start again from the beginning.

Two sticky cause bits record which monitor triggered a reset. Software clears them by writing ones through a small write port. A phase output shows which interval is currently being timed.

Top module: `supply_reset_seq`

## Requirements
- R1: After `rst_n` and while either monitor flag is low, `phase` is 0 (hold) and `sys_rst` is 1.
- R2: When the flags become good after the power-on flag was low, phase 1 (bias settling) lasts exactly POR_EXT_NS·CLK_KHZ/10^6 cycles. After a dip of the brown-out flag alone, phase 1 is skipped.
- R3: Phases move only forward, 0→1→2→3→4. Phase 2 (regulator settling) lasts exactly BOR_EXT_NS·CLK_KHZ/10^6 cycles.
- R4: Phase 3 (power-up timer) lasts 0 cycles for `pwrt_sel`=0. For code k≥1 it lasts 2^k·CLK_KHZ cycles, i.e. 2^k ms. With code 0, phase 2 is followed directly by phase 4.
- R5: A monitor flag driven low is seen as phase 0 with `sys_rst`=1 within three clock edges, whatever the phase. On recovery, the full regulator interval and power-up delay are timed again from zero.
- R6: `cause[0]` is set when the power-on flag is low and `cause[1]` is set when the brown-out flag is low. Each bit stays set afterwards.
- R7: A cycle with `clr_we`=1 clears each cause bit whose `clr_data` bit is 1 and leaves bits written with 0 unchanged. A set condition in the same cycle wins over the clear.
- R8: `sys_rst` is 0 exactly when `phase` is 4 (run).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous initialisation of the sequencer flops, active low |
| por_ok_in | input | 1 | Supply above power-on level (asynchronous) |
| bor_ok_in | input | 1 | Supply above brown-out level (asynchronous) |
| pwrt_sel | input | 3 | Power-up delay code |
| clr_we | input | 1 | Cause register write strobe |
| clr_data | input | 2 | Write-one-to-clear mask for the cause bits |
| sys_rst | output | 1 | System reset, active high |
| phase | output | 3 | Current phase: 0 hold, 1 bias, 2 regulator, 3 power-up, 4 run |
| cause | output | 2 | Sticky causes: bit 0 power-on, bit 1 brown-out |

## Verification
A corrupted interval counter shows up directly as a phase whose length differs from the exact cycle count, so every phase length is measured on the `phase` port. A wrong phase ordering shows up as a backward or skipped step. A missed return to hold after a monitor drop shows up three edges after the drop as a nonzero phase or a low `sys_rst`. A lost or stuck cause bit shows up on `cause` in the cycle after its set or clear.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;
    typedef enum logic [2:0] {
        PH_HOLD  = 3'd0,
        PH_BIAS  = 3'd1,
        PH_REG   = 3'd2,
        PH_PWRT  = 3'd3,
        PH_RUN   = 3'd4
    } phase_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/srs_pwrt_len.sv
module srs_pwrt_len #(
    parameter int CYC_PER_MS = 8000,
    parameter int CW         = 20
) (
    input  logic [2:0]    code,
    output logic [CW-1:0] len
);
    logic [CW-1:0] base;
    always_comb begin
        base = CW'(CYC_PER_MS);
        // code k>=1 gives 2^k ms; code 0 gives no delay
        len  = (code == 3'd0) ? '0 : (base << code);
    end
endmodule

// File: rtl/srs_cause.sv
module srs_cause (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_low,
    input  logic       bor_low,
    input  logic       clr_we,
    input  logic [1:0] clr_data,
    output logic [1:0] cause
);
    logic [1:0] cause_d, cause_q;
    always_comb begin
        cause_d = cause_q;
        if (clr_we) cause_d = cause_d & ~clr_data;
        if (por_low) cause_d[0] = 1'b1;
        if (bor_low) cause_d[1] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cause_q <= 2'b00;
        else        cause_q <= cause_d;
    end
    assign cause = cause_q;
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
    import supply_rst_pkg::*;
#(
    parameter int CLK_KHZ    = 8000,
    parameter int POR_EXT_NS = 30000,
    parameter int BOR_EXT_NS = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok_in,
    input  logic       bor_ok_in,
    input  logic [2:0] pwrt_sel,
    input  logic       clr_we,
    input  logic [1:0] clr_data,
    output logic       sys_rst,
    output logic [2:0] phase,
    output logic [1:0] cause
);
    localparam int POR_RAW = (CLK_KHZ * POR_EXT_NS) / 1000000;
    localparam int BOR_RAW = (CLK_KHZ * BOR_EXT_NS) / 1000000;
    localparam int POR_CYC = (POR_RAW < 1) ? 1 : POR_RAW;
    localparam int BOR_CYC = (BOR_RAW < 1) ? 1 : BOR_RAW;
    localparam int MAX_PWRT = 128 * CLK_KHZ;
    localparam int MAX_A = (POR_CYC > BOR_CYC) ? POR_CYC : BOR_CYC;
    localparam int MAX_C = (MAX_A > MAX_PWRT) ? MAX_A : MAX_PWRT;
    localparam int CW = $clog2(MAX_C + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          por_pend;
        logic          rst;
    } seq_t;

    seq_t st_d, st_q;
    logic [1:0] ok_sync;
    logic por_ok, bor_ok;
    logic [CW-1:0] pwrt_len;

    srs_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bor_ok_in, por_ok_in}), .q(ok_sync)
    );
    assign por_ok = ok_sync[0];
    assign bor_ok = ok_sync[1];

    srs_pwrt_len #(.CYC_PER_MS(CLK_KHZ), .CW(CW)) u_len (
        .code(pwrt_sel), .len(pwrt_len)
    );

    srs_cause u_cause (
        .clk(clk), .rst_n(rst_n),
        .por_low(!por_ok), .bor_low(!bor_ok),
        .clr_we(clr_we), .clr_data(clr_data), .cause(cause)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_HOLD: begin
                if (por_ok && bor_ok) begin
                    if (st_q.por_pend) begin
                        st_d.ph  = PH_BIAS;
                        st_d.cnt = CW'(POR_CYC - 1);
                    end else begin
                        st_d.ph  = PH_REG;
                        st_d.cnt = CW'(BOR_CYC - 1);
                    end
                end
            end
            PH_BIAS: begin
                if (st_q.cnt == '0) begin
                    st_d.ph       = PH_REG;
                    st_d.cnt      = CW'(BOR_CYC - 1);
                    st_d.por_pend = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_REG: begin
                if (st_q.cnt == '0) begin
                    if (pwrt_len == '0) begin
                        st_d.ph = PH_RUN;
                    end else begin
                        st_d.ph  = PH_PWRT;
                        st_d.cnt = pwrt_len - 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
            PH_PWRT: begin
                if (st_q.cnt == '0) st_d.ph = PH_RUN;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_RUN:  st_d.ph = PH_RUN;
            default: st_d.ph = PH_HOLD;
        endcase
        if (!por_ok || !bor_ok) begin
            st_d.ph  = PH_HOLD;
            st_d.cnt = '0;
        end
        if (!por_ok) st_d.por_pend = 1'b1;
        st_d.rst = (st_d.ph != PH_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph       <= PH_HOLD;
            st_q.cnt      <= '0;
            st_q.por_pend <= 1'b1;
            st_q.rst      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sys_rst = st_q.rst;
    assign phase   = st_q.ph;
endmodule

// File: rtl/srs_checker.sv
module srs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       por_ok_in,
    input logic       bor_ok_in,
    input logic       sys_rst,
    input logic [2:0] phase,
    input logic [1:0] cause,
    input logic       clr_we,
    input logic [1:0] clr_data
);
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
    logic warm;
    assign warm = (warm_q == 2'd3);

    AST_RUN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) == (sys_rst == 1'b0)); // R8
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= 3'd4); // R3
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && phase == 3'd4 && $past(phase) != 3'd4) |->
        ($past(phase) == 3'd3 || $past(phase) == 3'd2)); // R4
    AST_PWRT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && phase == 3'd3 && $past(phase) != 3'd3) |-> $past(phase) == 3'd2); // R3
    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && (!$past(bor_ok_in, 3) || !$past(por_ok_in, 3))) |->
        (phase == 3'd0 && sys_rst)); // R5
    AST_BOR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(bor_ok_in, 3)) |-> cause[1]); // R6
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(cause[0]) && !($past(clr_we) && $past(clr_data[0]))) |-> cause[0]); // R7
endmodule

bind supply_reset_seq srs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .por_ok_in(por_ok_in), .bor_ok_in(bor_ok_in),
    .sys_rst(sys_rst), .phase(phase), .cause(cause),
    .clr_we(clr_we), .clr_data(clr_data)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int KHZ = 100;
    localparam int POR_N = 3;    // 30 us at 100 kHz
    localparam int BOR_N = 10;   // 100 us at 100 kHz

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_ok_in = 1'b0, bor_ok_in = 1'b0;
    logic [2:0] pwrt_sel = 3'd0;
    logic clr_we = 1'b0;
    logic [1:0] clr_data = 2'b00;
    logic sys_rst;
    logic [2:0] phase;
    logic [1:0] cause;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    supply_reset_seq #(.CLK_KHZ(KHZ), .POR_EXT_NS(30000), .BOR_EXT_NS(100000)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_ok_in(por_ok_in), .bor_ok_in(bor_ok_in),
        .pwrt_sel(pwrt_sel), .clr_we(clr_we), .clr_data(clr_data),
        .sys_rst(sys_rst), .phase(phase), .cause(cause)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_clr(input logic [1:0] m);
        clr_we = 1'b1; clr_data = m;
        @(negedge clk);
        clr_we = 1'b0; clr_data = 2'b00;
    endtask

    function automatic int pwrt_cycles(input int code);
        return (code == 0) ? 0 : (1 << code) * KHZ;
    endfunction

    // counts sampled cycles per phase until run; checks order and release
    task automatic measure(input int exp_bias, input int code, input string tag);
        int n[5];
        int last, bad_order, bad_rst;
        for (int i = 0; i < 5; i++) n[i] = 0;
        last = 0; bad_order = 0; bad_rst = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (int'(phase) < last) bad_order++;
            last = int'(phase);
            if (sys_rst != (phase != 3'd4)) bad_rst++;
            if (phase <= 3'd4) n[phase]++;
            if (phase == 3'd4) break;
        end
        chk({"R2 bias length ", tag}, n[1], exp_bias);
        chk({"R3 regulator length ", tag}, n[2], BOR_N);
        chk({"R4 power-up length ", tag}, n[3], pwrt_cycles(code));
        chk({"R3 order ", tag}, bad_order, 0);
        chk({"R8 release ", tag}, bad_rst, 0);
        chk({"R8 run reached ", tag}, int'(sys_rst), 0);
    endtask

    task automatic t_reset;
        cyc(6);
        chk("R1 hold phase", int'(phase), 0);
        chk("R1 sys_rst", int'(sys_rst), 1);
        chk("R6 both causes", int'(cause), 3);
    endtask

    task automatic t_powerup;
        pwrt_sel = 3'd3;
        por_ok_in = 1'b1; bor_ok_in = 1'b1;
        measure(POR_N, 3, "powerup");
        cyc(5);
        chk("R8 stays run", int'(phase), 4);
    endtask

    task automatic t_clear;
        write_clr(2'b11);
        chk("R7 clear both", int'(cause), 0);
    endtask

    task automatic t_bor_dip;
        pwrt_sel = 3'd0;
        bor_ok_in = 1'b0;
        cyc(3);
        chk("R5 hold after drop", int'(phase), 0);
        chk("R5 reset after drop", int'(sys_rst), 1);
        cyc(4);
        bor_ok_in = 1'b1;
        measure(0, 0, "bor dip code0");
        chk("R6 bor cause only", int'(cause), 2);
        write_clr(2'b01);
        chk("R7 zero bit keeps", int'(cause), 2);
        write_clr(2'b10);
        chk("R7 clear bor", int'(cause), 0);
    endtask

    task automatic t_set_wins;
        pwrt_sel = 3'd1;
        bor_ok_in = 1'b0;
        cyc(4);
        write_clr(2'b10);
        chk("R7 set beats clear", int'(cause), 2);
        bor_ok_in = 1'b1;
        measure(0, 1, "code1");
        write_clr(2'b10);
    endtask

    task automatic t_mid_dip;
        int w;
        pwrt_sel = 3'd7;
        bor_ok_in = 1'b0;
        cyc(4);
        bor_ok_in = 1'b1;
        w = 0;
        while (phase != 3'd3 && w < 100) begin @(negedge clk); w++; end
        cyc(50);
        bor_ok_in = 1'b0;
        cyc(3);
        chk("R5 hold from power-up", int'(phase), 0);
        bor_ok_in = 1'b1;
        measure(0, 7, "restart code7");
    endtask

    task automatic t_por_loss;
        pwrt_sel = 3'd2;
        por_ok_in = 1'b0; bor_ok_in = 1'b0;
        cyc(3);
        chk("R5 hold after power loss", int'(phase), 0);
        cyc(3);
        chk("R6 por cause", int'(cause[0]), 1);
        por_ok_in = 1'b1; bor_ok_in = 1'b1;
        measure(POR_N, 2, "repower code2");
    endtask

    initial begin
        cyc(2);
        rst_n = 1'b1;
        t_reset();
        t_powerup();
        t_clear();
        t_bor_dip();
        t_set_wins();
        t_mid_dip();
        t_por_loss();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule